// File: doc/BRIEF.md
# UART Interrupt Source Ranking and Identification

This block collects the interrupt conditions of a 16550-style serial port and ranks them. It reports the winner as a 4-bit identification code and drives one interrupt request line. It holds three kinds of state. Receiver errors and modem-line changes arrive as one-cycle events and are held in sticky flags. The transmit-empty source is tracked by a small state machine. A second state machine measures receive-FIFO idle time to produce the character time-out. Receive-data-available is a level that the receive side supplies.

The host bus reaches the block through read and write strobes with an offset. The offsets it cares about are 0 (receive buffer read and holding-register write, only while the divisor-latch access bit is low), 2 (identification read), 5 (line status read) and 6 (modem status read). It decodes these accesses into the clear events for its own sources. For the line-status and modem-status registers, which sit outside the block, it also emits one-cycle clear strobes.

Transmit-empty tracker states: `TX_BUSY`, `TX_PEND`, `TX_SEEN`.
- `TX_BUSY` moves to `TX_PEND` on a rising edge of the empty input when no holding-register write happens in the same cycle.
- `TX_PEND` moves to `TX_SEEN` on an identification read while this source is the one reported.
- `TX_PEND` and `TX_SEEN` both return to `TX_BUSY` on a holding-register write or when the empty input drops.

Time-out timer states: `TO_IDLE`, `TO_WAIT`, `TO_FIRED`.
- Any state goes to `TO_IDLE` when FIFO mode is off or the FIFO is empty.
- Any state goes to `TO_WAIT`, with the count cleared, on a push or a receive-buffer read.
- `TO_IDLE` moves to `TO_WAIT` once the FIFO holds data.
- `TO_WAIT` counts character ticks and moves to `TO_FIRED` on the fourth one.
- `TO_FIRED` holds until it is cleared.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and right after it, with all inputs low, the code is 4'b0001 and `irq` is 0.
- R2: Any bit of `line_err` high for one cycle latches a line-status request, reported as code 4'b0110. A read at offset 5 pulses `clr_line_err` in the same cycle and removes the request at the next edge. If an error arrives in the same cycle as the read, the error wins.
- R3: While `rx_ready` is high and enabled, code 4'b0100 is reported in the same cycle, unless a higher source is present.
- R4: In FIFO mode, once the receive FIFO holds data and has seen no push and no receive-buffer read for 4 `char_tick` pulses, code 4'b1100 is reported from the cycle after the fourth pulse. After only three pulses it is not reported. A tick in the cycle where counting starts is not counted.
- R5: The time-out request is removed by a receive-buffer read (offset 0), a push, an empty FIFO, or `fifo_mode` low. It never appears while `fifo_mode` is low.
- R6: When received data and time-out are both pending and enabled, 4'b0100 is reported.
- R7: A rising edge of `tx_empty` raises the transmit-empty request, reported as code 4'b0010 from the next cycle.
- R8: The transmit-empty request is removed by an offset-2 read only if 4'b0010 is the code in that cycle. A holding-register write at offset 0 or a low `tx_empty` also removes it. It returns only on a new rising edge.
- R9: A one-cycle `modem_delta` latches a modem request, code 4'b0000. A read at offset 6 pulses `clr_modem_delta` in that cycle and removes the request at the next edge.
- R10: Priority from high to low: line status, then received data, then time-out, then transmit empty, then modem.
- R11: `int_en` bit 0 enables received data and time-out, bit 1 transmit empty, bit 2 line status and bit 3 modem. A disabled source never reaches the code or `irq`, but its pending state is kept.
- R12: `irq` is high exactly when bit 0 of the code is 0.
- R13: With `dlab` high, accesses at offset 0 are neither a receive-buffer read nor a holding-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| dlab | input | 1 | Divisor-latch access bit |
| int_en | input | 4 | Per-source enables |
| fifo_mode | input | 1 | FIFOs enabled |
| line_err | input | ERR_W | Overrun, parity, framing, break events |
| rx_ready | input | 1 | Receive data at or above trigger level |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_push | input | 1 | Character written into receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| tx_empty | input | 1 | Holding register empty |
| modem_delta | input | 1 | Change on a modem input line |
| iir_code | output | 4 | Identification code |
| irq | output | 1 | Interrupt request |
| clr_line_err | output | 1 | Clear strobe for line status bits |
| clr_modem_delta | output | 1 | Clear strobe for modem change bits |

## Verification
The bench builds the block with its default parameters: a 3-bit offset, four error flags and a time-out length of 4 character ticks. A limit of 4 keeps the boundary between the third and fourth tick within a few dozen cycles, and the bench checks that boundary directly. The 3-bit offset lets the divisor-latch aliasing at offset 0 and the four decoded offsets be driven in every combination.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'b0000,
        ID_NONE    = 4'b0001,
        ID_THRE    = 4'b0010,
        ID_RXDATA  = 4'b0100,
        ID_LINE    = 4'b0110,
        ID_TIMEOUT = 4'b1100
    } irq_id_e;

    typedef enum logic [1:0] {
        TX_BUSY,
        TX_PEND,
        TX_SEEN
    } tx_state_e;

    typedef enum logic [1:0] {
        TO_IDLE,
        TO_WAIT,
        TO_FIRED
    } to_state_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic thre;
        logic modem;
    } irq_src_t;

endpackage

// File: rtl/irq_sticky.sv
module irq_sticky #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_evt,
    input  logic [NUM-1:0] clr_evt,
    output logic [NUM-1:0] pend
);
    for (genvar i = 0; i < NUM; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (set_evt[i])
                flag_q <= 1'b1;
            else if (clr_evt[i])
                flag_q <= 1'b0;
        end
        assign pend[i] = flag_q;
    end
endmodule

// File: rtl/thre_tracker.sv
module thre_tracker
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic thr_write,
    input  logic iir_read,
    input  logic reported,
    output logic pending
);
    tx_state_e st_q, st_d;
    logic      empty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= TX_BUSY;
            empty_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            empty_q <= tx_empty;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_BUSY: begin
                if (tx_empty && !empty_q && !thr_write)
                    st_d = TX_PEND;
            end
            TX_PEND: begin
                if (thr_write || !tx_empty)
                    st_d = TX_BUSY;
                else if (iir_read && reported)
                    st_d = TX_SEEN;
            end
            TX_SEEN: begin
                if (thr_write || !tx_empty)
                    st_d = TX_BUSY;
            end
            default: st_d = TX_BUSY;
        endcase
    end

    always_comb begin
        pending = (st_q == TX_PEND);
    end
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout
    import uart_irq_pkg::*;
#(
    parameter int CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic rx_nonempty,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic char_tick,
    output logic fired
);
    localparam int CNT_W = (CHARS > 2) ? $clog2(CHARS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHARS - 1);

    to_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TO_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!fifo_mode || !rx_nonempty) begin
            st_d  = TO_IDLE;
            cnt_d = '0;
        end else if (rx_push || rx_pop) begin
            st_d  = TO_WAIT;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                TO_IDLE: begin
                    st_d  = TO_WAIT;
                    cnt_d = '0;
                end
                TO_WAIT: begin
                    if (char_tick) begin
                        if (cnt_q == LAST)
                            st_d = TO_FIRED;
                        else
                            cnt_d = cnt_q + 1'b1;
                    end
                end
                TO_FIRED: st_d = TO_FIRED;
                default:  st_d = TO_IDLE;
            endcase
        end
    end

    always_comb begin
        fired = (st_q == TO_FIRED);
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import uart_irq_pkg::*;
(
    input  irq_src_t req,
    output irq_id_e  code
);
    always_comb begin
        if (req.line)
            code = ID_LINE;
        else if (req.rxdata)
            code = ID_RXDATA;
        else if (req.timeout)
            code = ID_TIMEOUT;
        else if (req.thre)
            code = ID_THRE;
        else if (req.modem)
            code = ID_MODEM;
        else
            code = ID_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int ERR_W    = 4,
    parameter int TO_CHARS = 4,
    parameter int OFF_DATA = 0,
    parameter int OFF_IID  = 2,
    parameter int OFF_LINE = 5,
    parameter int OFF_MDM  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              dlab,
    input  logic [3:0]        int_en,
    input  logic              fifo_mode,
    input  logic [ERR_W-1:0]  line_err,
    input  logic              rx_ready,
    input  logic              rx_nonempty,
    input  logic              rx_push,
    input  logic              char_tick,
    input  logic              tx_empty,
    input  logic              modem_delta,
    output logic [3:0]        iir_code,
    output logic              irq,
    output logic              clr_line_err,
    output logic              clr_modem_delta
);
    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;
    localparam int SIDX_LINE = 0;
    localparam int SIDX_MDM  = 1;

    logic rd_data, wr_data, rd_iid, rd_line, rd_mdm;
    logic [1:0] sticky_set, sticky_clr, sticky_pend;
    logic thre_pend, to_fired;
    irq_src_t req;
    irq_id_e  code;

    always_comb begin
        rd_data = reg_rd && (reg_addr == ADDR_W'(OFF_DATA)) && !dlab;
        wr_data = reg_wr && (reg_addr == ADDR_W'(OFF_DATA)) && !dlab;
        rd_iid  = reg_rd && (reg_addr == ADDR_W'(OFF_IID));
        rd_line = reg_rd && (reg_addr == ADDR_W'(OFF_LINE));
        rd_mdm  = reg_rd && (reg_addr == ADDR_W'(OFF_MDM));
    end

    always_comb begin
        sticky_set[SIDX_LINE] = |line_err;
        sticky_clr[SIDX_LINE] = rd_line;
        sticky_set[SIDX_MDM]  = modem_delta;
        sticky_clr[SIDX_MDM]  = rd_mdm;
    end

    irq_sticky #(.NUM(2)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (sticky_set),
        .clr_evt (sticky_clr),
        .pend    (sticky_pend)
    );

    thre_tracker u_thre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_empty  (tx_empty),
        .thr_write (wr_data),
        .iir_read  (rd_iid),
        .reported  (code == ID_THRE),
        .pending   (thre_pend)
    );

    rx_timeout #(.CHARS(TO_CHARS)) u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode   (fifo_mode),
        .rx_nonempty (rx_nonempty),
        .rx_push     (rx_push),
        .rx_pop      (rd_data),
        .char_tick   (char_tick),
        .fired       (to_fired)
    );

    always_comb begin
        req.line    = sticky_pend[SIDX_LINE] && int_en[EN_LINE];
        req.rxdata  = rx_ready && int_en[EN_RX];
        req.timeout = to_fired && int_en[EN_RX];
        req.thre    = thre_pend && int_en[EN_TX];
        req.modem   = sticky_pend[SIDX_MDM] && int_en[EN_MDM];
    end

    irq_prio u_prio (
        .req  (req),
        .code (code)
    );

    always_comb begin
        iir_code        = code;
        irq             = ~code[0];
        clr_line_err    = rd_line;
        clr_modem_delta = rd_mdm;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int ADDR_W   = 3,
    parameter int ERR_W    = 4,
    parameter int OFF_DATA = 0,
    parameter int OFF_LINE = 5,
    parameter int OFF_MDM  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              dlab,
    input logic [3:0]        int_en,
    input logic              fifo_mode,
    input logic [ERR_W-1:0]  line_err,
    input logic              rx_ready,
    input logic              modem_delta,
    input logic [3:0]        iir_code
);
    // R2: a line-status read with no new error removes that source
    assert_line_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFF_LINE) && line_err == '0) |=> iir_code != 4'b0110);

    // R10: an enabled line error wins over everything at the next cycle
    assert_line_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en[2] && line_err != '0) |=> iir_code == 4'b0110);

    // R6: received data hides the time-out code
    assert_rx_over_to_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && int_en[0]) |-> iir_code != 4'b1100);

    // R5: no time-out outside FIFO mode
    assert_no_to_nonfifo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> iir_code != 4'b1100);

    // R8: a holding-register write removes transmit-empty
    assert_thr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_DATA) && !dlab) |=> iir_code != 4'b0010);

    // R9: a modem-status read with no new change removes that source
    assert_modem_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFF_MDM) && !modem_delta) |=> iir_code != 4'b0000);

    // R11: with nothing enabled, nothing is reported
    assert_all_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == 4'b0000) |-> iir_code == 4'b0001);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(
    .ADDR_W(ADDR_W), .ERR_W(ERR_W), .OFF_DATA(OFF_DATA),
    .OFF_LINE(OFF_LINE), .OFF_MDM(OFF_MDM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .dlab(dlab), .int_en(int_en), .fifo_mode(fifo_mode),
    .line_err(line_err), .rx_ready(rx_ready), .modem_delta(modem_delta),
    .iir_code(iir_code)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_rd = 0, reg_wr = 0, dlab = 0;
    logic [2:0] reg_addr = 0;
    logic [3:0] int_en = 0;
    logic       fifo_mode = 0;
    logic [3:0] line_err = 0;
    logic       rx_ready = 0, rx_nonempty = 0, rx_push = 0, char_tick = 0;
    logic       tx_empty = 0, modem_delta = 0;
    logic [3:0] iir_code;
    logic       irq, clr_line_err, clr_modem_delta;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .dlab(dlab), .int_en(int_en), .fifo_mode(fifo_mode),
        .line_err(line_err), .rx_ready(rx_ready), .rx_nonempty(rx_nonempty),
        .rx_push(rx_push), .char_tick(char_tick), .tx_empty(tx_empty),
        .modem_delta(modem_delta), .iir_code(iir_code), .irq(irq),
        .clr_line_err(clr_line_err), .clr_modem_delta(clr_modem_delta)
    );

    // behavioural reference
    bit m_line, m_mdm, m_prev_empty, to_run, to_hit;
    int m_tx;          // 0 idle, 1 raised, 2 acknowledged
    int to_n;

    function automatic logic [3:0] ref_code();
        if (m_line && int_en[2]) return 4'b0110;
        if (rx_ready && int_en[0]) return 4'b0100;
        if (to_hit && int_en[0]) return 4'b1100;
        if (m_tx == 1 && int_en[1]) return 4'b0010;
        if (m_mdm && int_en[3]) return 4'b0000;
        return 4'b0001;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_line = 0; m_mdm = 0; m_prev_empty = 0; m_tx = 0;
            to_run = 0; to_hit = 0; to_n = 0;
        end else begin
            bit rbr, thr, iid;
            logic [3:0] now;
            now = ref_code();
            rbr = reg_rd && reg_addr == 0 && !dlab;
            thr = reg_wr && reg_addr == 0 && !dlab;
            iid = reg_rd && reg_addr == 2;
            if (line_err != 0) m_line = 1; else if (reg_rd && reg_addr == 5) m_line = 0;
            if (modem_delta) m_mdm = 1; else if (reg_rd && reg_addr == 6) m_mdm = 0;
            if (thr || !tx_empty) m_tx = 0;
            else if (m_tx == 0 && !m_prev_empty) m_tx = 1;
            else if (m_tx == 1 && iid && now == 4'b0010) m_tx = 2;
            m_prev_empty = tx_empty;
            if (!fifo_mode || !rx_nonempty) begin to_run = 0; to_hit = 0; to_n = 0; end
            else if (rx_push || rbr) begin to_run = 1; to_hit = 0; to_n = 0; end
            else if (!to_run && !to_hit) begin to_run = 1; to_n = 0; end
            else if (to_run && char_tick) begin
                to_n++;
                if (to_n == 4) begin to_hit = 1; to_run = 0; end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] e;
            e = ref_code();
            check(iir_code == e, "R10 model code", iir_code, e);
            check(irq == !e[0], "R12 model irq", irq, !e[0]);
            check(clr_line_err == (reg_rd && reg_addr == 5), "R2 model strobe", clr_line_err, 0);
            check(clr_modem_delta == (reg_rd && reg_addr == 6), "R9 model strobe", clr_modem_delta, 0);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic expect_code(input logic [3:0] e, input string tag);
        @(negedge clk);
        check(iir_code == e, tag, iir_code, e);
        check(irq == !e[0], {tag, " irq"}, irq, !e[0]);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1; cyc(); char_tick = 0; cyc();
        end
    endtask

    task automatic rd(input logic [2:0] a);
        reg_rd = 1; reg_addr = a; cyc(); reg_rd = 0;
    endtask

    initial begin
        #2000000;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        check(iir_code == 4'b0001 && irq == 0, "R1 in reset", iir_code, 1);
        repeat (3) cyc();
        rst_n = 1;
        expect_code(4'b0001, "R1 after reset");
        cyc(); int_en = 4'hF;

        // line status
        line_err = 4'b0010; cyc(); line_err = 0;
        expect_code(4'b0110, "R2 error latched");
        reg_rd = 1; reg_addr = 5;
        @(negedge clk); check(clr_line_err == 1, "R2 clear strobe", clr_line_err, 1);
        cyc(); reg_rd = 0;
        expect_code(4'b0001, "R2 cleared by read");
        line_err = 4'b1000; reg_rd = 1; reg_addr = 5; cyc(); line_err = 0; reg_rd = 0;
        expect_code(4'b0110, "R2 error wins over read");
        cyc(); rd(5);
        expect_code(4'b0001, "R2 cleared again");

        // received data
        cyc(); rx_ready = 1;
        expect_code(4'b0100, "R3 data available");
        cyc(); line_err = 4'b0001; cyc(); line_err = 0;
        expect_code(4'b0110, "R10 line over data");
        cyc(); rd(5);
        expect_code(4'b0100, "R3 data after line cleared");
        cyc(); rx_ready = 0;

        // time-out
        fifo_mode = 1; rx_nonempty = 1; rx_push = 1; cyc(); rx_push = 0;
        ticks(3);
        expect_code(4'b0001, "R4 three ticks not enough");
        cyc(); ticks(1);
        expect_code(4'b1100, "R4 fourth tick fires");
        cyc(); rx_ready = 1;
        expect_code(4'b0100, "R6 data over timeout");
        cyc(); rx_ready = 0;
        expect_code(4'b1100, "R6 timeout back");
        cyc(); rd(0);
        expect_code(4'b0001, "R5 buffer read clears");
        ticks(4);
        expect_code(4'b1100, "R4 refires");
        cyc(); dlab = 1; rd(0); dlab = 0;
        expect_code(4'b1100, "R13 latch-mode read ignored");
        cyc(); rx_push = 1; cyc(); rx_push = 0;
        expect_code(4'b0001, "R5 push clears");
        cyc(); fifo_mode = 0; ticks(6);
        expect_code(4'b0001, "R5 no timeout outside fifo mode");
        cyc(); rx_nonempty = 0; fifo_mode = 1;

        // transmit empty
        cyc(); tx_empty = 1; cyc();
        expect_code(4'b0010, "R7 rising edge");
        cyc(); rd(2);
        expect_code(4'b0001, "R8 ident read clears");
        repeat (3) cyc();
        expect_code(4'b0001, "R8 stays cleared while empty");
        cyc(); tx_empty = 0; cyc(); tx_empty = 1; cyc();
        expect_code(4'b0010, "R7 new edge");
        cyc(); modem_delta = 1; cyc(); modem_delta = 0;
        expect_code(4'b0010, "R10 tx over modem");
        cyc(); dlab = 1; reg_wr = 1; reg_addr = 0; cyc(); reg_wr = 0; dlab = 0;
        expect_code(4'b0010, "R13 latch-mode write ignored");
        cyc(); reg_wr = 1; reg_addr = 0; cyc(); reg_wr = 0;
        expect_code(4'b0000, "R8 write clears, R9 modem shows");
        reg_rd = 1; reg_addr = 6;
        @(negedge clk); check(clr_modem_delta == 1, "R9 clear strobe", clr_modem_delta, 1);
        cyc(); reg_rd = 0;
        expect_code(4'b0001, "R9 modem cleared");

        cyc(); tx_empty = 0; cyc(); tx_empty = 1; cyc();
        line_err = 4'b0100; cyc(); line_err = 0;
        expect_code(4'b0110, "R10 line over tx");
        cyc(); rd(2);
        expect_code(4'b0110, "R8 ident read of other source");
        cyc(); rd(5);
        expect_code(4'b0010, "R8 tx kept when not reported");
        cyc(); rd(2);
        expect_code(4'b0001, "R8 cleared when reported");

        // enables
        cyc(); int_en = 4'b0000; line_err = 4'b0001; cyc(); line_err = 0;
        expect_code(4'b0001, "R11 disabled source hidden");
        cyc(); int_en = 4'b0100;
        expect_code(4'b0110, "R11 enabling reveals, R12 irq");
        cyc(); rd(5);
        expect_code(4'b0001, "R12 idle irq low");

        repeat (3) cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule